// File: doc/BRIEF.md
# Parallel Bus Capture Decoder

The block watches sixteen single-bit digital lanes and turns them into data words. One lane may be chosen as a sampling clock. A word is then taken on its rising transitions, on its falling transitions, or on both. With the clock turned off, a word is taken whenever any lane inside the chosen group changes value. All lanes, including the clock lane, are first passed through a two-flop synchroniser. Edges and changes are found by comparing each synchronised sample with the one taken a cycle earlier.

A three-bit preset selects the word width, the lane group and the bit order. Ascending presets take word bit 0 from the lowest lane of the group. Reversed presets take word bit 0 from the highest lane of the group. An 8-bit word is zero-extended to 16 bits. Every word comes out with a one-cycle valid strobe and a width flag.

A master enable gates the output. The configuration inputs are only taken in while the enable is low, so a running capture never sees its settings change.

Top module: `pbus_capture`

## Requirements
- R1: While rst_ni is low and after its release, `valid_o`, `wide_o` and `word_o` are all zero until the first word is captured.
- R2: A change on `lanes_i` that causes a capture raises `valid_o` on the third rising clock edge after the change (two synchroniser flops plus the output register).
- R3: With `clk_on_i`=1 and `edge_sel_i`=0, one word is captured per 0-to-1 transition of lane `clk_lane_i`; 1-to-0 transitions and data-lane changes capture nothing.
- R4: With `edge_sel_i`=1, only 1-to-0 transitions of the clock lane capture a word.
- R5: With `edge_sel_i`=2 or 3, every transition of the clock lane captures its own word.
- R6: With `clk_on_i`=0, a word is captured whenever any lane inside the preset's group changes; changes on lanes outside the group capture nothing.
- R7: Ascending presets map word bit i to lane base+i: preset 0 uses lanes 7..0, preset 1 lanes 15..8, preset 2 lanes 15..0; codes 6 and 7 act as preset 0.
- R8: Reversed presets map word bit 0 to the top lane of the group, with lower lanes for higher bits: preset 3 starts at lane 7 (group 0..7), preset 4 at lane 15 (group 8..15), preset 5 at lane 15 (all lanes).
- R9: Presets 2 and 5 give `wide_o`=1. All other presets give `wide_o`=0, with `word_o[15:8]` zero.
- R10: While `enable_i` is low, `valid_o` stays low whatever the lanes do.
- R11: `clk_on_i`, `clk_lane_i`, `edge_sel_i` and `preset_i` are sampled only while `enable_i` is low; changes made while enabled are ignored.
- R12: Each capture gives a `valid_o` pulse of exactly one cycle. Raising `enable_i` produces no word unless a capturing event follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Master capture enable |
| clk_on_i | input | 1 | 1: use a lane as the sampling clock; 0: capture on data change |
| clk_lane_i | input | 4 | Index of the clock lane |
| edge_sel_i | input | 2 | 0 rising, 1 falling, 2/3 both edges |
| preset_i | input | 3 | Lane group, width and bit order preset |
| lanes_i | input | 16 | Asynchronous digital lanes |
| valid_o | output | 1 | One-cycle strobe for a captured word |
| wide_o | output | 1 | 1 for a 16-bit word, 0 for an 8-bit word |
| word_o | output | 16 | Captured word, zero-extended when 8-bit |

## Verification
A lane change shows up on `valid_o` three rising edges later. `enable_i` reaches the output gate one edge later, and configuration is loaded on the edge after the enable is seen low. The bench drives every input just after a falling edge and samples one nanosecond later. The latency scenario samples at the second and third falling edges after the stimulus and expects the strobe only at the third. The other scenarios let each stimulus settle for four cycles, and a capture log filled on falling edges counts the strobes and keeps the captured words.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  localparam int unsigned LANES  = 16;
  localparam int unsigned LANE_W = $clog2(LANES);
  localparam int unsigned HALF   = LANES / 2;

  localparam logic [1:0] EDGE_RISE = 2'd0;
  localparam logic [1:0] EDGE_FALL = 2'd1;

  typedef struct packed {
    logic              clk_on;
    logic [LANE_W-1:0] clk_lane;
    logic [1:0]        edge_sel;
    logic [2:0]        preset;
  } cfg_t;

  typedef struct packed {
    logic              wide;
    logic              rev;
    logic [LANE_W-1:0] base;
  } layout_t;

  // codes 6/7 fall back to the low ascending group
  function automatic layout_t decode_preset(logic [2:0] p);
    layout_t l;
    l.rev  = (p == 3'd3) || (p == 3'd4) || (p == 3'd5);
    l.wide = (p == 3'd2) || (p == 3'd5);
    l.base = ((p == 3'd1) || (p == 3'd4)) ? LANE_W'(HALF) : '0;
    return l;
  endfunction
endpackage

// File: rtl/pbus_sync.sv
module pbus_sync #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int unsigned s = 0; s < STAGES; s++) chain_q[s] <= '0;
    end else begin
      chain_q[0] <= d_i;
      for (int unsigned s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pbus_map.sv
module pbus_map
  import pbus_pkg::*;
(
  input  logic [LANES-1:0] lanes_i,
  input  layout_t          layout_i,
  output logic [LANES-1:0] word_o
);
  logic [LANE_W-1:0] top_off;
  assign top_off = layout_i.wide ? LANE_W'(LANES - 1) : LANE_W'(HALF - 1);

  for (genvar b = 0; b < LANES; b++) begin : g_bit
    logic [LANE_W-1:0] fwd_idx, rev_idx, src_idx;
    assign fwd_idx = layout_i.base + LANE_W'(b);
    assign rev_idx = layout_i.base + top_off - LANE_W'(b);
    assign src_idx = layout_i.rev ? rev_idx : fwd_idx;
    if (b < HALF) begin : g_lo
      assign word_o[b] = lanes_i[src_idx];
    end else begin : g_hi
      assign word_o[b] = layout_i.wide & lanes_i[src_idx];
    end
  end
endmodule

// File: rtl/pbus_event.sv
module pbus_event
  import pbus_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LANES-1:0] cur_i,
  input  cfg_t             cfg_i,
  input  layout_t          layout_i,
  output logic             hit_o
);
  logic [LANES-1:0] prev_q;
  logic [LANES-1:0] grp_mask;
  logic             clk_now, clk_was, clk_hit, data_hit;

  // history follows the lanes at all times, so enabling never sees a stale sample
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= cur_i;
  end

  for (genvar j = 0; j < LANES; j++) begin : g_mask
    localparam bit UPPER = (j >= HALF);
    assign grp_mask[j] = layout_i.wide |
                         (UPPER ? layout_i.base[LANE_W-1] : ~layout_i.base[LANE_W-1]);
  end

  assign clk_now  = cur_i[cfg_i.clk_lane];
  assign clk_was  = prev_q[cfg_i.clk_lane];
  assign data_hit = |((cur_i ^ prev_q) & grp_mask);

  always_comb begin
    case (cfg_i.edge_sel)
      EDGE_RISE: clk_hit = clk_now & ~clk_was;
      EDGE_FALL: clk_hit = ~clk_now & clk_was;
      default:   clk_hit = clk_now ^ clk_was;
    endcase
  end

  assign hit_o = cfg_i.clk_on ? clk_hit : data_hit;
endmodule

// File: rtl/pbus_capture.sv
module pbus_capture
  import pbus_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              clk_on_i,
  input  logic [LANE_W-1:0] clk_lane_i,
  input  logic [1:0]        edge_sel_i,
  input  logic [2:0]        preset_i,
  input  logic [LANES-1:0]  lanes_i,
  output logic              valid_o,
  output logic              wide_o,
  output logic [LANES-1:0]  word_o
);
  cfg_t             cfg_q;
  logic             en_q;
  layout_t          layout;
  logic [LANES-1:0] lanes_sync;
  logic [LANES-1:0] word_map;
  logic             hit;

  assign layout = decode_preset(cfg_q.preset);

  pbus_sync #(.WIDTH(LANES), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (lanes_i),
    .q_o    (lanes_sync)
  );

  pbus_map i_map (
    .lanes_i  (lanes_sync),
    .layout_i (layout),
    .word_o   (word_map)
  );

  pbus_event i_event (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cur_i    (lanes_sync),
    .cfg_i    (cfg_q),
    .layout_i (layout),
    .hit_o    (hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      en_q    <= 1'b0;
      valid_o <= 1'b0;
      wide_o  <= 1'b0;
      word_o  <= '0;
    end else begin
      en_q <= enable_i;
      if (!enable_i) begin
        cfg_q.clk_on   <= clk_on_i;
        cfg_q.clk_lane <= clk_lane_i;
        cfg_q.edge_sel <= edge_sel_i;
        cfg_q.preset   <= preset_i;
      end
      valid_o <= en_q & hit;
      if (en_q & hit) begin
        word_o <= word_map;
        wide_o <= layout.wide;
      end
    end
  end
endmodule

// File: rtl/pbus_capture_chk.sv
module pbus_capture_chk
  import pbus_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             enable_i,
  input logic             en_q,
  input cfg_t             cfg_q,
  input logic             valid_o,
  input logic             wide_o,
  input logic [LANES-1:0] word_o
);
  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |-> (!valid_o && !wide_o && word_o == '0));

  a_r10_gated_by_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(enable_i, 2));

  a_r9_narrow_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !wide_o) |-> (word_o[LANES-1:HALF] == '0));

  a_r9_width_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(valid_o)) |-> (wide_o == $past(wide_o)));

  a_r11_cfg_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && $past(en_q)) |-> $stable(cfg_q));

  a_r3_rise_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && cfg_q.clk_on && cfg_q.edge_sel == EDGE_RISE) |=> !valid_o);

  a_r4_fall_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && cfg_q.clk_on && cfg_q.edge_sel == EDGE_FALL) |=> !valid_o);
endmodule

bind pbus_capture pbus_capture_chk i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .enable_i (enable_i),
  .en_q     (en_q),
  .cfg_q    (cfg_q),
  .valid_o  (valid_o),
  .wide_o   (wide_o),
  .word_o   (word_o)
);

// File: tb/test_pbus_capture.sv
`timescale 1ns/1ps
module test_pbus_capture;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        enable_i = 1'b0;
  logic        clk_on_i = 1'b0;
  logic [3:0]  clk_lane_i = '0;
  logic [1:0]  edge_sel_i = '0;
  logic [2:0]  preset_i = '0;
  logic [15:0] lanes_i = '0;
  logic        valid_o, wide_o;
  logic [15:0] word_o;

  int n_chk = 0;
  int n_fail = 0;
  int ncap = 0;
  logic [15:0] cap_w [64];
  logic        cap_wide [64];

  always #2 clk_i = ~clk_i;

  pbus_capture i_pbus_capture (
    .clk_i(clk_i), .rst_ni(rst_ni), .enable_i(enable_i), .clk_on_i(clk_on_i),
    .clk_lane_i(clk_lane_i), .edge_sel_i(edge_sel_i), .preset_i(preset_i),
    .lanes_i(lanes_i), .valid_o(valid_o), .wide_o(wide_o), .word_o(word_o)
  );

  always @(negedge clk_i) begin
    if (valid_o && ncap < 64) begin
      cap_w[ncap]    <= word_o;
      cap_wide[ncap] <= wide_o;
      ncap           <= ncap + 1;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
    #1;
  endtask

  task automatic setup(input logic on, input logic [3:0] lane, input logic [1:0] es,
                       input logic [2:0] p, input logic [15:0] init);
    enable_i   = 1'b0;
    clk_on_i   = on;
    clk_lane_i = lane;
    edge_sel_i = es;
    preset_i   = p;
    lanes_i    = init;
    idle(5);
    enable_i = 1'b1;
    idle(3);
    ncap = 0;
  endtask

  task automatic drive(input logic [15:0] l);
    lanes_i = l;
    idle(4);
  endtask

  function automatic logic [15:0] ref_word(input logic [2:0] p, input logic [15:0] l);
    logic [15:0] r = '0;
    case (p)
      3'd1: r[7:0] = l[15:8];
      3'd2: r = l;
      3'd3: for (int i = 0; i < 8; i++) r[i] = l[7-i];
      3'd4: for (int i = 0; i < 8; i++) r[i] = l[15-i];
      3'd5: for (int i = 0; i < 16; i++) r[i] = l[15-i];
      default: r[7:0] = l[7:0];
    endcase
    return r;
  endfunction

  task automatic t_reset;
    idle(1);
    chk("R1 valid", 16'(valid_o), 16'd0);
    chk("R1 word", word_o, 16'h0000);
    chk("R1 wide", 16'(wide_o), 16'd0);
  endtask

  task automatic t_latency;
    setup(1'b0, 4'd0, 2'd0, 3'd0, 16'h0000);
    lanes_i = 16'h0001;
    @(negedge clk_i); @(negedge clk_i); #1;
    chk("R2 early", 16'(valid_o), 16'd0);
    @(negedge clk_i); #1;
    chk("R2 due", 16'(valid_o), 16'd1);
    chk("R2 word", word_o, 16'h0001);
    @(negedge clk_i); #1;
    chk("R12 one cycle", 16'(valid_o), 16'd0);
  endtask

  task automatic t_rise;
    setup(1'b1, 4'd12, 2'd0, 3'd0, 16'h0000);
    drive(16'h00A5);
    drive(16'h10A5);
    drive(16'h003C);
    drive(16'h103C);
    chk("R3 count", 16'(ncap), 16'd2);
    chk("R3 word0", cap_w[0], 16'h00A5);
    chk("R3 word1", cap_w[1], 16'h003C);
  endtask

  task automatic t_fall;
    setup(1'b1, 4'd9, 2'd1, 3'd0, 16'h0000);
    drive(16'h0211);
    drive(16'h0011);
    drive(16'h0222);
    drive(16'h0022);
    chk("R4 count", 16'(ncap), 16'd2);
    chk("R4 word0", cap_w[0], 16'h0011);
    chk("R4 word1", cap_w[1], 16'h0022);
  endtask

  task automatic t_both;
    for (int es = 2; es < 4; es++) begin
      setup(1'b1, 4'd10, 2'(es), 3'd0, 16'h0000);
      drive(16'h0401);
      drive(16'h0002);
      drive(16'h0003);
      chk("R5 count", 16'(ncap), 16'd2);
      chk("R5 word0", cap_w[0], 16'h0001);
      chk("R5 word1", cap_w[1], 16'h0002);
    end
  endtask

  task automatic t_clkoff;
    setup(1'b0, 4'd0, 2'd0, 3'd1, 16'h0000);
    drive(16'h0008);
    chk("R6 outside ignored", 16'(ncap), 16'd0);
    drive(16'h0208);
    chk("R6 inside count", 16'(ncap), 16'd1);
    chk("R6 inside word", cap_w[0], 16'h0002);
  endtask

  task automatic t_map;
    logic [15:0] pat = 16'hB2C5;
    for (int p = 0; p < 8; p++) begin
      setup(1'b0, 4'd0, 2'd0, 3'(p), ~pat);
      drive(pat);
      chk(p inside {3, 4, 5} ? "R8 reversed word" : "R7 ascending word",
          cap_w[0], ref_word(3'(p), pat));
      chk("R9 width flag", 16'(cap_wide[0]), 16'((p == 2) || (p == 5)));
    end
  endtask

  task automatic t_enable;
    setup(1'b0, 4'd0, 2'd0, 3'd2, 16'h0000);
    enable_i = 1'b0;
    idle(2);
    ncap = 0;
    drive(16'hFFFF);
    drive(16'h1234);
    chk("R10 disabled", 16'(ncap), 16'd0);
    chk("R10 valid low", 16'(valid_o), 16'd0);
  endtask

  task automatic t_cfg_locked;
    setup(1'b0, 4'd0, 2'd0, 3'd0, 16'h0000);
    preset_i = 3'd5;
    clk_on_i = 1'b1;
    idle(2);
    drive(16'h0003);
    chk("R11 count", 16'(ncap), 16'd1);
    chk("R11 old preset", cap_w[0], 16'h0003);
    chk("R11 old width", 16'(cap_wide[0]), 16'd0);
  endtask

  task automatic t_enable_quiet;
    enable_i = 1'b0;
    clk_on_i = 1'b0;
    preset_i = 3'd2;
    lanes_i  = 16'h5A5A;
    idle(5);
    ncap = 0;
    enable_i = 1'b1;
    idle(6);
    chk("R12 no word on enable", 16'(ncap), 16'd0);
  endtask

  initial begin
    #(200000 * 4);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    t_reset();
    rst_ni = 1'b1;
    t_reset();
    t_latency();
    t_rise();
    t_fall();
    t_both();
    t_clkoff();
    t_map();
    t_enable();
    t_cfg_locked();
    t_enable_quiet();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule